// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters on a single output line. A host pushes bytes into a 16-entry queue through a simple write strobe. It can keep pushing while earlier characters are still being shifted out, so a steady supply of data leaves the line as an unbroken train of characters.

Each character begins with a low start bit. The data follows, least-significant bit first, then an optional parity bit, then one or two high stop bits. The data length (7 or 8 bits), the parity mode (off, even, odd) and the stop-bit count are run-time inputs. They are captured when a character is taken from the queue. Timing comes from an external enable that pulses at sixteen times the bit rate. A status output reports when the queue and the shifter have both drained.

Top module: `async_tx_buffered`

## Requirements
- R1: While no character is in flight, `txd` is high (mark).
- R2: A character is a low start bit, then data least-significant bit first, then (if enabled) a parity bit, then stop bits at high level. Characters leave in the order they were written.
- R3: With `cfg_len7`=1 only bits [6:0] of the written byte are sent (7 data bits), and the parity bit or the first stop bit follows bit 6 directly. With `cfg_len7`=0 all 8 bits are sent.
- R4: With `cfg_par_en`=1 a parity bit follows the data. With `cfg_par_odd`=0 it makes the count of ones in data plus parity even. With `cfg_par_odd`=1 it makes that count odd. With `cfg_par_en`=0 no parity bit is sent.
- R5: `cfg_stop2`=0 sends one high stop bit and `cfg_stop2`=1 sends two.
- R6: Every bit of a character lasts exactly 16 pulses of `tick`. A lone byte written to an empty idle block keeps `tx_end` low for 16*F+1 clock cycles when `tick` is high every cycle, where F is the bit count of the character.
- R7: The queue holds 16 entries. `fifo_level` gives the number of entries waiting (0 to 16), and `fifo_full` is high when it is 16.
- R8: A write while `fifo_full` is high is dropped. The level does not grow, the byte is never sent, and `overflow` is high for exactly the one following cycle.
- R9: If the queue is not empty when the final stop bit ends, the next start bit begins at once. Start-bit falling edges are then exactly 16*F tick-cycles apart.
- R10: `tx_end` is high only when the queue is empty and the final stop bit has finished, and `txd` is then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable pulse at 16x the bit rate |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to send |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_level | output | 5 | Entries waiting in the queue |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| txd | output | 1 | Serial output line |
| tx_end | output | 1 | Queue empty and last stop bit finished |

## Verification
The assertions check on every cycle that the line rests at mark when no character is in flight. They also check that a load drives the start bit low, that the line never moves between tick pulses, that the level stays within bounds, that a write into a full queue pulses `overflow` without growing the level, and that `tx_end` coincides with an empty queue and a high line. Other behaviour only appears across whole characters, so the bench's scenarios must show it. This covers the data bits, their order and masking at 7 bits, the parity value, the stop-bit count, the exact character length in cycles, the absence of a gap between queued characters, and the fact that a dropped byte never reaches the line.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_cfg_t;

endpackage

// File: rtl/async_tx_fifo.sv
module async_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     level,
  output logic              ovf_pulse
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;
  logic              wr_ok, rd_ok;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign level = count;
  assign head  = mem[rptr];
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= wr_en && full;
      if (wr_ok) wptr <= next_ptr(wptr);
      if (rd_ok) rptr <= next_ptr(rptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/async_tx_bit_timer.sv
module async_tx_bit_timer #(
  parameter int OVS = 16,
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic bit_end
);

  logic [TW-1:0] cnt;

  assign bit_end = run && tick && (cnt == TW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= (cnt == TW'(OVS - 1)) ? '0 : cnt + TW'(1);
    end
  end

endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_cfg_t        cfg_in,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  input  logic              bit_end,
  output logic              load,
  output logic              busy,
  output logic              frame_done,
  output logic              txd
);

  tx_state_e         st;
  frame_cfg_t        cur;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     bidx;
  logic              pbit;
  logic              last_data;

  // parity over the active data bits; odd mode inverts the even result
  function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                     input logic short_len,
                                     input logic odd);
    logic [DATA_W-1:0] m;
    m = d;
    if (short_len) m[DATA_W-1] = 1'b0;
    return (^m) ^ odd;
  endfunction

  function automatic logic [IW-1:0] last_index(input logic short_len);
    return short_len ? IW'(DATA_W - 2) : IW'(DATA_W - 1);
  endfunction

  assign busy       = (st != ST_IDLE);
  assign last_data  = (bidx == last_index(cur.len7));
  assign frame_done = bit_end && ((st == ST_STOP1 && !cur.stop2) || st == ST_STOP2);
  assign load       = !q_empty && (st == ST_IDLE || frame_done);

  always_comb begin
    case (st)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[bidx];
      ST_PAR:   txd = pbit;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cur   <= '0;
      shreg <= '0;
      bidx  <= '0;
      pbit  <= 1'b0;
    end else if (load) begin
      st    <= ST_START;
      cur   <= cfg_in;
      shreg <= q_head;
      bidx  <= '0;
      pbit  <= parity_of(q_head, cfg_in.len7, cfg_in.par_odd);
    end else if (bit_end) begin
      case (st)
        ST_START: st <= ST_DATA;
        ST_DATA: begin
          if (last_data) st <= cur.par_en ? ST_PAR : ST_STOP1;
          else           bidx <= bidx + IW'(1);
        end
        ST_PAR:   st <= ST_STOP1;
        ST_STOP1: st <= cur.stop2 ? ST_STOP2 : ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_tx_buffered.sv
module async_tx_buffered
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OVS    = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_len7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fifo_full,
  output logic [CW-1:0]     fifo_level,
  output logic              overflow,
  output logic              txd,
  output logic              tx_end
);

  frame_cfg_t        cfg_now;
  logic [DATA_W-1:0] q_head;
  logic              q_empty;
  logic              frm_load;
  logic              frm_busy;
  logic              frm_done;
  logic              bit_end;

  assign cfg_now = '{len7: cfg_len7, par_en: cfg_par_en,
                     par_odd: cfg_par_odd, stop2: cfg_stop2};

  async_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (frm_load),
    .head      (q_head),
    .empty     (q_empty),
    .full      (fifo_full),
    .level     (fifo_level),
    .ovf_pulse (overflow)
  );

  async_tx_bit_timer #(.OVS(OVS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (frm_load),
    .run     (frm_busy),
    .tick    (tick),
    .bit_end (bit_end)
  );

  async_tx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_in     (cfg_now),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .bit_end    (bit_end),
    .load       (frm_load),
    .busy       (frm_busy),
    .frame_done (frm_done),
    .txd        (txd)
  );

  assign tx_end = q_empty && !frm_busy;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_level,
  input logic          overflow,
  input logic          txd,
  input logic          tx_end,
  input logic          busy,
  input logic          load
);

  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick && !load |=> $stable(txd));

  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH));

  a_r8_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && fifo_full |=> overflow);

  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(wr_en && fifo_full));

  a_r8_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && fifo_full && !load |=> fifo_level == $past(fifo_level));

  a_r10_end_state: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> txd && fifo_level == '0);

endmodule

bind async_tx_buffered async_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .wr_en      (wr_en),
  .fifo_full  (fifo_full),
  .fifo_level (fifo_level),
  .overflow   (overflow),
  .txd        (txd),
  .tx_end     (tx_end),
  .busy       (frm_busy),
  .load       (frm_load)
);

// File: tb/async_tx_buffered_test.sv
`timescale 1ns/1ps
module async_tx_buffered_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fifo_full, overflow, txd, tx_end;
  logic [4:0] fifo_level;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int P = 1;
  int tdiv = 0;
  bit gap_chk = 0, have_prev = 0;
  int prev_edge = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_tx_buffered uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_full(fifo_full), .fifo_level(fifo_level), .overflow(overflow),
    .txd(txd), .tx_end(tx_end)
  );

  // tick every P cycles, changed away from the rising edge
  initial forever begin
    @(negedge clk);
    tdiv = tdiv + 1;
    tick = ((tdiv % P) == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int frame_bits();
    return 1 + (cfg_len7 ? 7 : 8) + (cfg_par_en ? 1 : 0) + (cfg_stop2 ? 2 : 1);
  endfunction

  // driver: push to the design and to the scoreboard when accepted
  task automatic wr_byte(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    if (!fifo_full) exp_q.push_back(cfg_len7 ? {1'b0, d[6:0]} : d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int guard = 0;
    while (!tx_end && guard < 20000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all written bytes sent", exp_q.size(), 0);
    chk(txd == 1'b1, tag, int'(txd), 1);
  endtask

  // monitor: decode each character at bit centres and compare
  initial begin
    logic last = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && last && txd === 1'b0) begin
        int nd, f;
        logic [7:0] got, e;
        logic pb, ep;
        f  = frame_bits();
        nd = cfg_len7 ? 7 : 8;
        if (gap_chk && have_prev)
          chk(cyc - prev_edge == 16 * f, "R9 back-to-back spacing", cyc - prev_edge, 16 * f);
        prev_edge = cyc;
        have_prev = 1;
        repeat (8 * P) @(negedge clk);
        chk(txd == 1'b0, "R2 start bit low", int'(txd), 0);
        got = 8'h00;
        for (int i = 0; i < nd; i++) begin
          repeat (16 * P) @(negedge clk);
          got[i] = txd;
        end
        e = (exp_q.size() > 0) ? exp_q[0] : 8'hXX;
        if (cfg_par_en) begin
          repeat (16 * P) @(negedge clk);
          pb = txd;
          ep = (^e) ^ cfg_par_odd;
          chk(pb == ep, cfg_par_odd ? "R4 odd parity" : "R4 even parity", int'(pb), int'(ep));
        end
        repeat (16 * P) @(negedge clk);
        chk(txd == 1'b1, "R5 first stop bit", int'(txd), 1);
        if (cfg_stop2) begin
          repeat (16 * P) @(negedge clk);
          chk(txd == 1'b1, "R5 second stop bit", int'(txd), 1);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected character", int'(got), -1);
        end else begin
          e = exp_q.pop_front();
          chk(got == e, cfg_len7 ? "R3 7-bit data" : "R2 8-bit data", int'(got), int'(e));
        end
      end
      last = txd;
    end
  end

  task automatic finish_up();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(txd == 1'b1, "R1 idle line high after reset", int'(txd), 1);
    chk(tx_end == 1'b1, "R10 tx_end after reset", int'(tx_end), 1);
    chk(fifo_level == 0, "R7 level after reset", int'(fifo_level), 0);
    chk(fifo_full == 1'b0, "R7 full after reset", int'(fifo_full), 0);

    // 8N1, single byte, exact length
    P = 1;
    wr_byte(8'hA5);
    n = 0;
    while (!tx_end && n < 5000) begin n++; @(negedge clk); end
    chk(n == 16 * frame_bits() + 1, "R6 tx_end low span (16 ticks per bit)", n, 16 * frame_bits() + 1);
    wait_idle("R1 line high after 8N1");

    // 7 bits, even parity, two stop bits, back to back
    cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 1;
    gap_chk = 1; have_prev = 0;
    wr_byte(8'h7F); wr_byte(8'h00); wr_byte(8'hB5);
    wait_idle("R10 line high after 7E2");

    // 8 bits, odd parity, one stop bit
    cfg_len7 = 0; cfg_par_odd = 1; cfg_stop2 = 0;
    have_prev = 0;
    wr_byte(8'h00); wr_byte(8'hFF); wr_byte(8'h81);
    wait_idle("R10 line high after 8O1");

    // 7 bits, no parity: bit 7 masked, stop follows bit 6
    cfg_len7 = 1; cfg_par_en = 0;
    have_prev = 0;
    wr_byte(8'hFF); wr_byte(8'h80);
    wait_idle("R3 line high after 7N1");

    // slower tick: 8 bits even parity, two stop bits
    gap_chk = 0;
    P = 3;
    cfg_len7 = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 1;
    wr_byte(8'h3C); wr_byte(8'hC3);
    wait_idle("R6 line high after divided tick");

    // fill the queue, then overflow
    P = 1;
    cfg_len7 = 0; cfg_par_en = 0; cfg_stop2 = 0;
    gap_chk = 1; have_prev = 0;
    for (int k = 0; k < 17; k++) wr_byte(8'(k * 13 + 1));
    chk(fifo_level == 16, "R7 level when full", int'(fifo_level), 16);
    chk(fifo_full == 1'b1, "R7 full flag", int'(fifo_full), 1);
    wr_byte(8'hEE);
    chk(overflow == 1'b1, "R8 overflow pulse", int'(overflow), 1);
    chk(fifo_level == 16, "R8 level unchanged by dropped write", int'(fifo_level), 16);
    @(negedge clk);
    chk(overflow == 1'b0, "R8 overflow lasts one cycle", int'(overflow), 0);
    wait_idle("R9 line high after queued burst");
    chk(fifo_level == 0, "R10 level zero at end", int'(fifo_level), 0);

    finish_up();
  end

endmodule